// File: doc/BRIEF.md
# Matrix LRU Victim Tracker

This block keeps the recency order of `N` page frames and names the least recently used frame as the next replacement victim. Recency is held in an N-by-N bit matrix. Each frame owns one row and one column. A reference to frame k writes ones across row k and then zeroes down column k, so the diagonal cell (k,k) ends at 0. Each row, read as an unsigned binary number with column N-1 as the most significant bit, ranks its frame. The frame with the smallest row value is the victim. The matrix changes only when a frame is referenced. There is no periodic tick.

A memory-management front end pulses `ref_valid` with `ref_idx` on every frame access. When it needs a frame to evict, it pulses `query`. One cycle later, `victim_idx` carries the answer and `victim_valid` is high for that cycle.

A small reply state machine sets the answer timing. It has two states, `ST_IDLE` and `ST_REPLY`. From either state it moves to `ST_REPLY` when `query` is high and to `ST_IDLE` when it is low. `victim_valid` is high exactly while the machine is in `ST_REPLY`.

Top module: `lru_victim_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, every matrix bit is 0 and `victim_valid` is 0. A reset clears all recency history.
- R2: A reference to frame k sets every bit of row k except (k,k) to 1 and clears column k in every row, all in one clock edge.
- R3: The reported victim is the frame whose row has the smallest value. Once every frame has been referenced, this is the frame whose latest reference is the oldest.
- R4: When several rows share the smallest value, the lowest frame index wins. After reset, a query reports frame 0, and frames never referenced are chosen lowest index first.
- R5: `victim_valid` is 1 in the cycle after a cycle with `query` high and 0 otherwise. `victim_idx` is meaningful while `victim_valid` is 1.
- R6: When `ref_valid` and `query` are high in the same cycle, the answer reflects the matrix before that reference.
- R7: Without a reference the matrix does not change, so repeated queries over idle cycles return the same victim.
- R8: With N=4 and the references 0,1,2,3,2,1,0,3,2,3, a following query reports frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_idx | input | IW | Index of the referenced frame, IW = clog2(N) |
| query | input | 1 | Request for a victim |
| victim_idx | output | IW | Least recently used frame, valid with `victim_valid` |
| victim_valid | output | 1 | Answer to the previous cycle's query |

## Verification
The assertions assume that `ref_idx` is below N whenever `ref_valid` is high. They also assume that reset is held for at least one clock before any stimulus is applied. The bench draws every frame index from the range 0 to N-1, drives reset low before the first edge, and changes inputs only on falling edges. Random streams mix references, queries and both together, so the rule that a query sees the matrix before a same-cycle reference (R6) is exercised often.

// File: rtl/lru_pkg.sv
package lru_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } reply_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lru_matrix.sv
module lru_matrix #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IW-1:0]    ref_idx,
    output logic [N*N-1:0]   mat_flat
);
    // cell (r,c) lives at bit r*N + c
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic cell_q;
            logic hit_row;
            logic hit_col;
            assign hit_row = ref_valid && (ref_idx == IW'(r));
            assign hit_col = ref_valid && (ref_idx == IW'(c));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= 1'b0;
                end else if (hit_col) begin
                    cell_q <= 1'b0;          // column clear wins, covers diagonal
                end else if (hit_row) begin
                    cell_q <= 1'b1;
                end
            end
            assign mat_flat[r*N + c] = cell_q;
        end
    end
endmodule

// File: rtl/lru_argmin.sv
module lru_argmin #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N*N-1:0] mat_flat,
    output logic [IW-1:0]  min_idx
);
    logic [N-1:0] best_val;
    always_comb begin
        best_val = mat_flat[0 +: N];
        min_idx  = '0;
        for (int k = 1; k < N; k++) begin
            if (mat_flat[k*N +: N] < best_val) begin   // strict: lowest index keeps ties
                best_val = mat_flat[k*N +: N];
                min_idx  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/lru_reply_fsm.sv
module lru_reply_fsm
    import lru_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          query,
    input  logic [IW-1:0] cand_idx,
    output logic [IW-1:0] victim_idx,
    output logic          victim_valid
);
    reply_state_e state_q, state_d;
    logic [IW-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = query ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = query ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (query) begin
            idx_q <= cand_idx;
        end
    end

    always_comb begin
        victim_valid = (state_q == ST_REPLY);
        victim_idx   = idx_q;
    end
endmodule

// File: rtl/lru_victim_tracker.sv
module lru_victim_tracker #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_valid,
    input  logic [IW-1:0] ref_idx,
    input  logic          query,
    output logic [IW-1:0] victim_idx,
    output logic          victim_valid
);
    logic [N*N-1:0] mat_flat;
    logic [IW-1:0]  cand_idx;

    lru_matrix #(.N(N), .IW(IW)) u_mat (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid),
        .ref_idx(ref_idx), .mat_flat(mat_flat)
    );

    lru_argmin #(.N(N), .IW(IW)) u_min (
        .mat_flat(mat_flat), .min_idx(cand_idx)
    );

    lru_reply_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .query(query), .cand_idx(cand_idx),
        .victim_idx(victim_idx), .victim_valid(victim_valid)
    );
endmodule

// File: rtl/lru_victim_tracker_chk.sv
module lru_victim_tracker_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_valid,
    input logic [IW-1:0] ref_idx,
    input logic          query,
    input logic [IW-1:0] victim_idx,
    input logic          victim_valid,
    input logic [N*N-1:0] mat_flat
);
    logic [IW-1:0] last_idx;
    logic [N-1:0]  diag;
    logic [N-1:0]  last_row;
    logic [N-1:0]  last_col;

    always_ff @(posedge clk) last_idx <= ref_idx;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            diag[k]     = mat_flat[k*N + k];
            last_row[k] = mat_flat[int'(last_idx)*N + k];
            last_col[k] = mat_flat[k*N + int'(last_idx)];
        end
    end

    AST_DIAG_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) diag == '0); // R2
    AST_ROW_SET:     assert property (@(posedge clk) disable iff (!rst_n)
                         ref_valid |=> (last_row | (N'(1) << last_idx)) == {N{1'b1}}); // R2
    AST_COL_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
                         ref_valid |=> last_col == '0); // R2
    AST_HOLD_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
                         !ref_valid |=> $stable(mat_flat)); // R7
    AST_REPLY_RISE:  assert property (@(posedge clk) disable iff (!rst_n)
                         query |=> victim_valid); // R5
    AST_REPLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                         !query |=> !victim_valid); // R5
    AST_IDX_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
                         victim_valid |-> int'(victim_idx) < N); // R3
endmodule

bind lru_victim_tracker lru_victim_tracker_chk #(.N(N), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .query(query), .victim_idx(victim_idx), .victim_valid(victim_valid),
    .mat_flat(mat_flat)
);

// File: tb/sim_lru_victim_tracker.sv
`timescale 1ns/1ps
module sim_lru_victim_tracker;
    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          query = 1'b0;
    logic [IW-1:0] victim_idx;
    logic          victim_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int last_use [N];
    int tstamp   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    lru_victim_tracker #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
        .query(query), .victim_idx(victim_idx), .victim_valid(victim_valid)
    );

    function automatic int model_victim();
        int best = 0;
        for (int k = 1; k < N; k++) if (last_use[k] < last_use[best]) best = k;
        return best;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < N; k++) last_use[k] = -1;
        tstamp = 0;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic step(input bit rv, input int ri, input bit q, input string tag);
        int exp_idx;
        ref_valid = rv;
        ref_idx   = IW'(ri);
        query     = q;
        exp_idx   = model_victim();          // R6: answer uses pre-update order
        if (rv) begin
            tstamp++;
            last_use[ri] = tstamp;
        end
        @(negedge clk);
        check({tag, " R5 valid"}, int'(victim_valid), int'(q));
        if (q) check(tag, int'(victim_idx), exp_idx);
        ref_valid = 1'b0;
        query     = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", int'(victim_valid), 0);

        step(0, 0, 1, "R4 query after reset gives 0");
        step(1, 2, 0, "R4 ref");
        step(0, 0, 1, "R4 tie among unreferenced");
        step(1, 0, 0, "R4 ref");
        step(0, 0, 1, "R4 next unreferenced");
        step(1, 1, 0, "R2 ref");
        step(1, 3, 0, "R2 ref");
        step(0, 0, 1, "R3 all referenced oldest");
        step(1, 2, 1, "R6 same cycle ref and query");
        step(0, 0, 1, "R3 after ref");

        repeat (5) step(0, 0, 0, "R7 idle");
        step(0, 0, 1, "R7 unchanged after idle");
        step(0, 0, 1, "R7 back to back query");

        // R1: history cleared by reset
        foreach (seq[i]) step(1, (i + 1) % N, 0, "R1 fill");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid low in reset", int'(victim_valid), 0);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        step(0, 0, 1, "R1 reset clears history");

        // R8 directed sequence
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        foreach (seq[i]) step(1, seq[i], 0, "R8 ref");
        step(0, 0, 1, "R8 sequence victim");
        check("R8 victim is frame 1", int'(victim_idx), 1);

        // R3 random streams against the recency model
        for (int i = 0; i < 4000; i++) begin
            bit rv = ($urandom_range(0, 3) != 0);
            bit q  = ($urandom_range(0, 2) == 0);
            step(rv, $urandom_range(0, N - 1), q, "R3 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule